// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers the data bytes of one write command into a page-sized latch and writes them to a storage array once the command is closed. A command is opened with a start address. The low address bits give the first position inside the page, and the high bits choose the page. Data bytes then stream in, and each byte lands at the next position in the page. The position wraps inside the page, so a byte sent after the page is full overwrites one buffered earlier.

When the command closes with a Stop, the block runs a commit. It first reads the old page contents, so that positions the command did not touch keep their old values. It then writes the whole page back in ascending offset order. After that it holds busy for a fixed programming interval, counted in clocks.

A command can end without a commit. This happens when it is closed by a repeated Start, when it carries no data bytes, or when write protect is high at the moment of Stop. In each of these cases the block returns to idle at once and busy never rises. Write protect is looked at only on the Stop cycle. Changing it later has no effect on a commit that has already started.

Data input is a valid/ready stream. A byte is taken on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only while a command is open and does not depend on `in_valid`. A source that sees `in_ready` low must hold its byte, or drop it if the command is over. Bytes presented while the block is idle or busy are never taken. The control strobes and `busy` are plain single-cycle or level signals.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, `busy`, `in_ready` and `arr_en` are low.
- R2: A pulse on `cmd_open` while idle opens a command. From the next cycle, `in_ready` is high until a Stop or repeated Start closes the command.
- R3: The first byte of a command goes to page offset `cmd_addr % PAGE_BYTES` of page `cmd_addr / PAGE_BYTES`. Each following byte goes to the next offset, wrapping from `PAGE_BYTES-1` to 0. A later byte at the same offset replaces an earlier one.
- R4: The array is never written before Stop. A command closed by `cmd_restart` (with `cmd_stop` low) writes nothing and leaves `busy` low.
- R5: A commit writes all `PAGE_BYTES` locations of the selected page, exactly once each, in ascending offset order. Locations not written by the command keep their previous contents.
- R6: If `wp` is high on the Stop cycle, nothing is written, `busy` stays low, and a new command may be opened on the next cycle.
- R7: Changes of `wp` after the Stop cycle do not affect a commit that is in progress.
- R8: `busy` rises on the cycle after an accepted Stop. It stays high for exactly `2*PAGE_BYTES + 1 + WRITE_CYCLES` cycles.
- R9: A command closed by Stop with no data byte accepted starts no commit, and `busy` stays low.
- R10: A byte accepted on the same cycle as Stop belongs to the command and is committed.
- R11: While `busy` is high, `in_ready` is low and `cmd_open` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_open | input | 1 | Strobe: open a write command at `cmd_addr` |
| cmd_addr | input | ADDR_W | Start address of the command |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Block can take a data byte |
| in_data | input | 8 | Data byte |
| cmd_stop | input | 1 | Strobe: Stop closes the command and may commit |
| cmd_restart | input | 1 | Strobe: repeated Start discards the command |
| wp | input | 1 | Write protect, sampled on the Stop cycle |
| busy | output | 1 | Commit or programming interval in progress |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write (read when low) |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, valid one cycle after a read |

## Verification
The case where a data byte is accepted on the very cycle that Stop arrives is the one that matters. If the byte were missed, the commit would silently lose the last byte, or would not start at all for a single-byte command. The bench provokes this on purpose by raising `in_valid` and `cmd_stop` together, both for a one-byte command and for a command that already holds bytes. It then compares the whole array against its own arithmetic model, and checks that the `busy` length matches a real commit. A second same-cycle case drives `cmd_open` with a data byte while busy, and checks that neither one leaves a trace in the array.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_LOAD,
    ST_PROG,
    ST_WAIT
  } pwb_state_t;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int PAGE_BYTES = 128,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [7:0]       fill_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] taken;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      taken <= '0;
    end else if (wr_en) begin
      taken[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot[wr_idx] <= wr_data;
    end else if (fill_en && !taken[fill_idx]) begin
      slot[fill_idx] <= fill_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int CYCLES = 500000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_open,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              cmd_stop,
  input  logic              cmd_restart,
  input  logic              wp,
  output logic              busy,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);
  import pwb_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - IDX_W;
  localparam logic [IDX_W:0] IDX_END  = (IDX_W+1)'(PAGE_BYTES);
  localparam logic [IDX_W:0] IDX_LAST = (IDX_W+1)'(PAGE_BYTES - 1);

  pwb_state_t       state;
  logic [PG_W-1:0]  page;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W:0]   idx;
  logic             have_data;
  logic             accept;
  logic             open_ok;
  logic             wait_done;
  logic [7:0]       lat_q;

  assign accept   = in_valid && in_ready;
  assign open_ok  = cmd_open && (state == ST_IDLE);
  assign in_ready = (state == ST_COLLECT);
  assign busy     = (state == ST_LOAD) || (state == ST_PROG) || (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      page      <= '0;
      ptr       <= '0;
      idx       <= '0;
      have_data <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_open) begin
            page      <= cmd_addr[ADDR_W-1:IDX_W];
            ptr       <= cmd_addr[IDX_W-1:0];
            have_data <= 1'b0;
            state     <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (accept) begin
            ptr       <= ptr + 1'b1;
            have_data <= 1'b1;
          end
          if (cmd_stop) begin
            idx   <= '0;
            state <= ((have_data || accept) && !wp) ? ST_LOAD : ST_IDLE;
          end else if (cmd_restart) begin
            state <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          if (idx == IDX_END) begin
            idx   <= '0;
            state <= ST_PROG;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PROG: begin
          if (idx == IDX_LAST) begin
            state <= ST_WAIT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (wait_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pwb_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (open_ok),
    .wr_en     (accept),
    .wr_idx    (ptr),
    .wr_data   (in_data),
    .fill_en   ((state == ST_LOAD) && (idx != '0)),
    .fill_idx  (IDX_W'(idx - 1'b1)),
    .fill_data (arr_rdata),
    .rd_idx    (idx[IDX_W-1:0]),
    .rd_data   (lat_q)
  );

  pwb_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_WAIT),
    .done  (wait_done)
  );

  assign arr_en    = ((state == ST_LOAD) && (idx != IDX_END)) || (state == ST_PROG);
  assign arr_we    = (state == ST_PROG);
  assign arr_addr  = {page, idx[IDX_W-1:0]};
  assign arr_wdata = lat_q;
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              cmd_stop,
  input logic              cmd_restart,
  input logic              wp,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_busy_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stop));

  assert_restart_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cmd_restart && !cmd_stop) |=> (!busy && !in_ready));

  assert_prog_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[IDX_W-1:0] == IDX_W'($past(arr_addr[IDX_W-1:0]) + 1'b1)) &&
      (arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W])));

  assert_wp_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cmd_stop && wp) |=> !busy);

  assert_no_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

bind pwb_ctrl pwb_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .cmd_stop    (cmd_stop),
  .cmd_restart (cmd_restart),
  .wp          (wp),
  .busy        (busy),
  .arr_we      (arr_we),
  .arr_addr    (arr_addr)
);

// File: tb/test_pwb_ctrl.sv
`timescale 1ns/1ps
module test_pwb_ctrl;
  localparam int AW = 6;
  localparam int P  = 8;
  localparam int WC = 20;
  localparam int MEMN = 1 << AW;
  localparam int BUSY_LEN = 2*P + 1 + WC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_open = 1'b0, in_valid = 1'b0, cmd_stop = 1'b0, cmd_restart = 1'b0, wp = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, arr_en, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata;

  logic [7:0] mem [MEMN];
  logic [7:0] expm [MEMN];
  int total = 0, bad = 0, wr_cnt = 0;

  always #2.5 clk = ~clk;

  pwb_ctrl #(.ADDR_W(AW), .PAGE_BYTES(P), .WRITE_CYCLES(WC)) i_pwb_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_open(cmd_open), .cmd_addr(cmd_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_stop(cmd_stop), .cmd_restart(cmd_restart), .wp(wp), .busy(busy),
    .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  always @(posedge clk) begin
    if (arr_en) begin
      if (arr_we) begin
        mem[arr_addr] <= arr_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        arr_rdata <= mem[arr_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int diffs = 0;
    for (int a = 0; a < MEMN; a++) if (mem[a] !== expm[a]) diffs++;
    chk(diffs == 0, req, diffs, 0);
  endtask

  task automatic open_cmd(input int addr);
    @(negedge clk);
    cmd_open = 1'b1; cmd_addr = AW'(addr);
    @(negedge clk);
    cmd_open = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_stop(input bit with_byte, input logic [7:0] d);
    cmd_stop = 1'b1;
    in_valid = with_byte; in_data = d;
    @(negedge clk);
    cmd_stop = 1'b0; in_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int o, input int n, input int i);
    return 8'((o*37 + n*11 + i*5 + 1) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n_busy;
    for (int a = 0; a < MEMN; a++) begin
      mem[a] = 8'((a*7 + 3) & 255);
      expm[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !in_ready && !arr_en, "R1 reset", {busy, in_ready, arr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of start offset, byte count (beyond page wraps, R3), and wp (R6).
    for (int o = 0; o < P; o++) begin
      for (int n = 0; n <= P + 3; n++) begin
        int pg = (o*3 + n) % (MEMN / P);
        bit prot = ((o + n) % 5 == 4);
        wr_cnt = 0;
        wp = prot;
        open_cmd(pg*P + o);
        chk(in_ready, "R2 ready after open", in_ready, 1);
        for (int i = 0; i < n; i++) send(pat(o, n, i));
        chk(wr_cnt == 0 && !busy, "R4 no write before stop", wr_cnt, 0);
        pulse_stop(1'b0, 8'h00);
        if (n > 0 && !prot) begin
          for (int i = 0; i < n; i++) expm[pg*P + (o + i) % P] = pat(o, n, i);
        end
        count_busy(n_busy);
        if (n == 0) chk(n_busy == 0, "R9 empty command", n_busy, 0);
        else if (prot) chk(n_busy == 0, "R6 protected", n_busy, 0);
        else chk(n_busy == BUSY_LEN, "R8 busy length", n_busy, BUSY_LEN);
        chk(wr_cnt == ((n > 0 && !prot) ? P : 0), "R5 page writes", wr_cnt, (n > 0 && !prot) ? P : 0);
        chk_mem("R3 R5 contents");
      end
    end
    wp = 1'b0;

    // R6: ready for a new command right after a protected stop.
    wp = 1'b1;
    open_cmd(5);
    send(8'hA1);
    pulse_stop(1'b0, 8'h00);
    wp = 1'b0;
    cmd_open = 1'b1; cmd_addr = AW'(9);
    @(negedge clk);
    cmd_open = 1'b0;
    chk(in_ready, "R6 immediate reopen", in_ready, 1);
    send(8'h5C);
    pulse_stop(1'b0, 8'h00);
    expm[9] = 8'h5C;
    count_busy(n_busy);
    chk_mem("R6 after reopen");

    // R4: repeated start discards.
    wr_cnt = 0;
    open_cmd(20);
    send(8'h11); send(8'h22);
    cmd_restart = 1'b1; in_valid = 1'b1; in_data = 8'h33;
    @(negedge clk);
    cmd_restart = 1'b0; in_valid = 1'b0;
    chk(!in_ready, "R4 restart closes", in_ready, 0);
    repeat (5) @(negedge clk);
    chk(!busy && wr_cnt == 0, "R4 restart no commit", wr_cnt, 0);
    chk_mem("R4 restart contents");

    // R10: byte on the stop cycle, single-byte command.
    open_cmd(33);
    pulse_stop(1'b1, 8'hE7);
    expm[33] = 8'hE7;
    count_busy(n_busy);
    chk(n_busy == BUSY_LEN, "R10 lone byte commits", n_busy, BUSY_LEN);
    chk_mem("R10 lone byte");

    // R10 with earlier bytes, plus R7 wp raised during commit.
    open_cmd(46);
    send(8'h01);
    pulse_stop(1'b1, 8'h02);
    expm[46] = 8'h01; expm[47] = 8'h02;
    wp = 1'b1;
    count_busy(n_busy);
    wp = 1'b0;
    chk(n_busy == BUSY_LEN, "R7 busy unaffected", n_busy, BUSY_LEN);
    chk_mem("R7 R10 contents");

    // R11: open and byte while busy are ignored.
    open_cmd(50);
    send(8'h77);
    pulse_stop(1'b0, 8'h00);
    expm[50] = 8'h77;
    repeat (3) @(negedge clk);
    chk(busy && !in_ready, "R11 not ready while busy", in_ready, 0);
    cmd_open = 1'b1; cmd_addr = AW'(60); in_valid = 1'b1; in_data = 8'h99;
    @(negedge clk);
    cmd_open = 1'b0; in_valid = 1'b0;
    count_busy(n_busy);
    @(negedge clk);
    chk(!in_ready, "R11 open ignored", in_ready, 0);
    chk_mem("R11 contents");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule